// File: doc/BRIEF.md
# Accumulator Processor Core Without Multiply

This block is a compact 8-bit processor built around one accumulator, a program counter and a zero flag. It reads both instructions and data from a single byte-wide memory through a synchronous port. Read data returns one cycle after the address is presented, and a write takes effect at the clock edge where the write strobe is high. Seven operations are provided: load, store, add, subtract, jump when zero, jump always and halt. There is no multiply instruction. Products are formed in software with a loop that adds one operand into a running total while a counter falls to zero. The loop tests the counter at its top, so a zero count yields a zero product.

Every instruction is two bytes: an opcode byte and then an 8-bit address byte. The core works through a multi-cycle sequence. It fetches the opcode, fetches the address byte, and then either finishes the instruction or makes one more access for the data operand. After a halt the core parks, and it holds until reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held, the core drives halted low, mem_we low and mem_addr 0x00. Reset clears the program counter, the accumulator and the zero flag, so execution starts at address 0x00 with the accumulator at 0 and a jump-when-zero not taken.
- R2: An instruction is an opcode byte at address p followed by an address byte at p+1. The next instruction starts at p+2 unless a jump is taken. Opcodes: 0x01 load, 0x02 store, 0x03 add, 0x04 subtract, 0x05 jump when zero, 0x06 jump always, 0x07 halt.
- R3: Load copies mem[addr] into the accumulator. Add and subtract combine the accumulator with mem[addr] and keep the low 8 bits, so 200+100 gives 44 and 44-50 gives 250.
- R4: Store writes the accumulator to mem[addr] with mem_we high for exactly one cycle.
- R5: Load, add and subtract set the zero flag when the new accumulator is 0 and clear it otherwise. Store and both jumps leave the flag unchanged.
- R6: Jump-when-zero loads the program counter with its address byte only when the zero flag is set. Jump-always loads it every time.
- R7: After a halt, halted is high and stays high until reset. While halted, mem_addr holds its value and mem_we stays low. The halt's address byte has no effect.
- R8: Any opcode value other than 0x01 to 0x07 acts as a no-operation. It changes neither the accumulator, the flag nor memory, and execution continues at p+2.
- R9: A repeated-addition multiply loop built from load, store, add, subtract, jump-when-zero and jump-always leaves the product a*b mod 256 in memory: 3*4 gives 12, and a zero count gives 0.
- R10: Load, add and subtract take 4 clock cycles. Store, both jumps, no-operations and halt take 3. halted rises at the clock edge that ends the halt's third cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 8 | Memory address for read or write |
| mem_we | output | 1 | Write strobe; mem_wdata is written to mem_addr |
| mem_wdata | output | 8 | Write data (accumulator) |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_addr |
| halted | output | 1 | High once a halt has executed |

## Verification
The assertions take for granted that the memory behaves as a one-cycle synchronous RAM. They assume mem_rdata is the byte at the address presented in the previous cycle, and that a strobed write lands before any later read. The bench meets this by modelling exactly that RAM around the core. It places programs and data only in disjoint regions, so stores never overwrite code. Random multiply operands keep the count at 20 or below, so every run reaches its halt well inside the per-run cycle limit.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    // Opcode byte values
    localparam int OPC_LOAD  = 1;
    localparam int OPC_STORE = 2;
    localparam int OPC_ADD   = 3;
    localparam int OPC_SUB   = 4;
    localparam int OPC_JZ    = 5;
    localparam int OPC_JMP   = 6;
    localparam int OPC_HALT  = 7;

    typedef enum logic [2:0] {
        ST_FOP,   // present opcode address
        ST_FARG,  // opcode on read data, present operand address
        ST_DEC,   // operand on read data, finish or start data access
        ST_EXE,   // data on read data, update accumulator
        ST_HALT
    } cpu_state_e;

    typedef enum logic [2:0] {
        K_NOP, K_LOAD, K_STORE, K_ADD, K_SUB, K_JZ, K_JMP, K_HALT
    } op_kind_e;

    typedef enum logic [1:0] {
        ALU_PASS, ALU_ADD, ALU_SUB
    } alu_op_e;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] opcode,
    output op_kind_e      kind,
    output alu_op_e       alu_op
);

    always_comb begin
        kind   = K_NOP;
        alu_op = ALU_PASS;
        if (opcode == DW'(OPC_LOAD)) begin
            kind = K_LOAD;
        end else if (opcode == DW'(OPC_STORE)) begin
            kind = K_STORE;
        end else if (opcode == DW'(OPC_ADD)) begin
            kind   = K_ADD;
            alu_op = ALU_ADD;
        end else if (opcode == DW'(OPC_SUB)) begin
            kind   = K_SUB;
            alu_op = ALU_SUB;
        end else if (opcode == DW'(OPC_JZ)) begin
            kind = K_JZ;
        end else if (opcode == DW'(OPC_JMP)) begin
            kind = K_JMP;
        end else if (opcode == DW'(OPC_HALT)) begin
            kind = K_HALT;
        end
    end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output logic          zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = b;
        endcase
        zero = (y == '0);
    end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          halted
);

    localparam int AW = DW;  // operand byte is a full address

    typedef struct packed {
        cpu_state_e    st;
        logic [AW-1:0] pc;
        logic [DW-1:0] acc;
        logic          zf;
        op_kind_e      kind;
        alu_op_e       aop;
    } core_regs_t;

    core_regs_t regs_d, regs_q;

    op_kind_e      dec_kind;
    alu_op_e       dec_aop;
    logic [DW-1:0] alu_y;
    logic          alu_zero;

    acc_cpu_decode #(.DW(DW)) u_decode (
        .opcode (mem_rdata),
        .kind   (dec_kind),
        .alu_op (dec_aop)
    );

    acc_cpu_alu #(.DW(DW)) u_alu (
        .op   (regs_q.aop),
        .a    (regs_q.acc),
        .b    (mem_rdata),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        regs_d    = regs_q;
        mem_addr  = regs_q.pc;
        mem_we    = 1'b0;
        mem_wdata = regs_q.acc;
        unique case (regs_q.st)
            ST_FOP: begin
                regs_d.pc = regs_q.pc + AW'(1);
                regs_d.st = ST_FARG;
            end
            ST_FARG: begin
                regs_d.kind = dec_kind;
                regs_d.aop  = dec_aop;
                regs_d.pc   = regs_q.pc + AW'(1);
                regs_d.st   = ST_DEC;
            end
            ST_DEC: begin
                regs_d.st = ST_FOP;
                unique case (regs_q.kind)
                    K_LOAD, K_ADD, K_SUB: begin
                        mem_addr  = mem_rdata;
                        regs_d.st = ST_EXE;
                    end
                    K_STORE: begin
                        mem_addr = mem_rdata;
                        mem_we   = 1'b1;
                    end
                    K_JMP: regs_d.pc = mem_rdata;
                    K_JZ: begin
                        if (regs_q.zf) regs_d.pc = mem_rdata;
                    end
                    K_HALT: regs_d.st = ST_HALT;
                    default: ;
                endcase
            end
            ST_EXE: begin
                regs_d.acc = alu_y;
                regs_d.zf  = alu_zero;
                regs_d.st  = ST_FOP;
            end
            default: regs_d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_FOP, pc: '0, acc: '0, zf: 1'b0,
                        kind: K_NOP, aop: ALU_PASS};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign halted = (regs_q.st == ST_HALT);

    // R4
    store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_we && $stable(mem_addr)));

    // R5
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_DEC && (regs_q.kind == K_STORE || regs_q.kind == K_JZ
                                 || regs_q.kind == K_JMP))
        |=> $stable(regs_q.zf));

    // R6
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_DEC && regs_q.kind == K_JMP)
        |=> (regs_q.pc == $past(mem_rdata)));

    // R3
    acc_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.st == ST_EXE && regs_q.kind == K_ADD)
        |=> (regs_q.acc == DW'($past(regs_q.acc) + $past(mem_rdata))));

endmodule

// File: tb/acc_cpu_core_tb_top.sv
`timescale 1ns/100ps
module acc_cpu_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;
    logic       mem_we, halted;
    logic [7:0] mem [256];

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    acc_cpu_core dut_i (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .halted(halted)
    );

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_mul(input int a, input int b);
        return (a * b) & 255;
    endfunction

    function automatic int exp_mul_cycles(input int b);
        return 10 + 28 * b;
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    endtask

    task automatic put(input int at, input int op, input int arg);
        mem[at]   = 8'(op);
        mem[at+1] = 8'(arg);
    endtask

    task automatic run(output int cyc, input bit check_reset);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (check_reset) begin
            chk(!halted, "R1 halted in reset", int'(halted), 0);
            chk(!mem_we, "R1 mem_we in reset", int'(mem_we), 0);
            chk(mem_addr == 8'h00, "R1 mem_addr in reset", int'(mem_addr), 0);
        end
        rst_n = 1'b1;
        cyc = 0;
        while (cyc < 5000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (halted) break;
        end
        chk(halted == 1'b1, "R7 halt reached", int'(halted), 1);
    endtask

    task automatic load_mul(input int a, input int b);
        clear_mem();
        put(0, 1, 8'h40);   // load b
        put(2, 5, 18);      // jz done
        put(4, 2, 8'h43);   // store cnt
        put(6, 1, 8'h44);   // load prod
        put(8, 3, 8'h41);   // add a
        put(10, 2, 8'h44);  // store prod
        put(12, 1, 8'h43);  // load cnt
        put(14, 4, 8'h42);  // sub one
        put(16, 6, 2);      // jmp loop
        put(18, 7, 0);      // halt
        mem[8'h40] = 8'(b);
        mem[8'h41] = 8'(a);
        mem[8'h42] = 8'd1;
        mem[8'h43] = 8'd0;
        mem[8'h44] = 8'd0;
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc;
        int a, b;
        logic [7:0] hold_addr;
        bit hold_ok;
        void'($urandom(32'd1234));

        // R9 directed 3*4, R10 cycle count, R1 reset state
        load_mul(3, 4);
        run(cyc, 1'b1);
        chk(mem[8'h44] == 8'd12, "R9 3*4 product", int'(mem[8'h44]), 12);
        chk(cyc == exp_mul_cycles(4), "R10 multiply cycles", cyc, exp_mul_cycles(4));

        // R7 hold while halted
        hold_addr = mem_addr;
        hold_ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!halted || mem_we || mem_addr != hold_addr) hold_ok = 1'b0;
        end
        chk(hold_ok, "R7 halted hold", int'(hold_ok), 1);

        // R9 zero count
        load_mul(9, 0);
        run(cyc, 1'b1);
        chk(mem[8'h44] == 8'd0, "R9 zero count product", int'(mem[8'h44]), 0);
        chk(cyc == exp_mul_cycles(0), "R10 zero count cycles", cyc, exp_mul_cycles(0));

        // R9 random products with wrap
        for (int t = 0; t < 12; t++) begin
            a = int'($urandom_range(255, 0));
            b = int'($urandom_range(20, 0));
            load_mul(a, b);
            run(cyc, 1'b0);
            chk(int'(mem[8'h44]) == exp_mul(a, b), "R9 random product",
                int'(mem[8'h44]), exp_mul(a, b));
        end

        // R3 wrap on add and subtract, R4 stores
        clear_mem();
        put(0, 1, 8'h70); put(2, 3, 8'h71); put(4, 2, 8'h72);
        put(6, 4, 8'h73); put(8, 2, 8'h74); put(10, 7, 0);
        mem[8'h70] = 8'd200; mem[8'h71] = 8'd100; mem[8'h73] = 8'd50;
        run(cyc, 1'b0);
        chk(mem[8'h72] == 8'd44, "R3 add wrap", int'(mem[8'h72]), 44);
        chk(mem[8'h74] == 8'd250, "R3 sub wrap", int'(mem[8'h74]), 250);

        // R5 store keeps flag, R6 conditional branches
        clear_mem();
        put(0, 1, 8'h51); put(2, 1, 8'h50); put(4, 2, 8'h52);
        put(6, 5, 12); put(8, 1, 8'h51); put(10, 2, 8'h60);
        put(12, 1, 8'h51); put(14, 5, 20); put(16, 2, 8'h61);
        put(18, 7, 0); put(20, 2, 8'h62); put(22, 7, 0);
        mem[8'h50] = 8'd0; mem[8'h51] = 8'd5;
        run(cyc, 1'b0);
        chk(mem[8'h60] == 8'hEE, "R5 flag kept over store, jz taken", int'(mem[8'h60]), 238);
        chk(mem[8'h61] == 8'd5, "R6 jz not taken path", int'(mem[8'h61]), 5);
        chk(mem[8'h62] == 8'hEE, "R6 jz not taken target untouched", int'(mem[8'h62]), 238);
        chk(mem[8'h52] == 8'd0, "R4 store value", int'(mem[8'h52]), 0);

        // R8 undefined opcodes, R7 halt operand ignored, R2 layout
        clear_mem();
        put(0, 1, 8'h51); put(2, 0, 8'h50); put(4, 8'hA5, 8'h50);
        put(6, 2, 8'h63); put(8, 7, 8'hFF);
        mem[8'h50] = 8'd0; mem[8'h51] = 8'd5;
        run(cyc, 1'b0);
        chk(mem[8'h63] == 8'd5, "R8 no-op keeps accumulator", int'(mem[8'h63]), 5);
        chk(cyc == 4 + 3 + 3 + 3 + 3, "R2 R8 no-op step cycles", cyc, 16);

        // R10 load then halt
        clear_mem();
        put(0, 1, 8'h51); put(2, 7, 0);
        mem[8'h51] = 8'd5;
        run(cyc, 1'b0);
        chk(cyc == 7, "R10 load plus halt cycles", cyc, 7);

        // R1 accumulator cleared by reset
        clear_mem();
        put(0, 2, 8'h65); put(2, 7, 0);
        run(cyc, 1'b1);
        chk(mem[8'h65] == 8'd0, "R1 accumulator cleared", int'(mem[8'h65]), 0);

        // R1 zero flag cleared by reset
        clear_mem();
        put(0, 5, 4); put(2, 7, 0); put(4, 2, 8'h66); put(6, 7, 0);
        run(cyc, 1'b0);
        chk(mem[8'h66] == 8'hEE, "R1 zero flag cleared", int'(mem[8'h66]), 238);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule